// File: doc/BRIEF.md
# Framebuffer Slot Scheduler

This block shares one external byte-wide SRAM between two clients: display refresh and host writes. It runs at twice the pixel rate. Each pixel period has two clock cycles. The first cycle is a read slot that fetches the framebuffer byte for an upcoming pixel. The second cycle is a write slot that retires one queued host write, if one is waiting. Because of this fixed split, the display side never waits for the host.

Host writes enter a queue. Each entry holds an 18-bit address and one data byte. When the queue is full, further pushes are dropped, and a sticky flag records that this happened. Each byte fetched for display is used as an index into a 256-entry palette of 9-bit colours, and the result is the pixel colour. The host loads the palette through its own port. The block keeps its own raster position. During blanking it issues no reads and drives black.

Top module: `fb_slot_sched`

## Requirements
- R1: Clock cycles alternate between a read slot and a write slot. The first cycle after reset is released is a read slot. `sram_oe` is high only in read slots and `sram_we` only in write slots, so the two are never high together.
- R2: In a write slot, `sram_we` is high exactly when the queue holds at least one entry. `sram_addr` and `sram_wdata` then carry the oldest entry. Entries reach the SRAM in the order they were accepted, one per write slot.
- R3: The queue holds `FIFO_DEPTH` entries, and `wr_full` is high while it holds that many. A push made while `wr_full` is high is dropped and never written to the SRAM.
- R4: `wr_ovf` is 0 after reset. It goes to 1 after a dropped push and stays at 1 until the next reset.
- R5: A pixel at raster position (x, y) is active when x < `H_ACTIVE` and y < `V_ACTIVE`. A frame lasts `H_TOTAL`*`V_TOTAL` pixel periods. For each active pixel, in raster order, one read slot has `sram_oe` high and `sram_addr` = y*`H_ACTIVE`+x. The address restarts at 0 each frame. `sram_oe` stays low for blanking positions.
- R6: The colour shown for an active pixel is the palette entry indexed by the byte read for it. When `pal_we` is high at a clock edge, the entry at `pal_idx` takes the value `pal_rgb`. The bit packing is red = bits 8:6, green = bits 5:3, blue = bits 2:0.
- R7: For blanking positions, `pix_de` is low and `pix_rgb` is 0, whatever the palette holds.
- R8: `pix_stb` pulses high for one cycle in every pixel period, always in a write slot. A byte read in a read slot appears on `pix_rgb` three cycles later, with `pix_stb` and `pix_de` high. It is then held for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, two cycles per pixel |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_push | input | 1 | Host write request into the queue |
| wr_addr | input | 18 | Framebuffer address of the host write |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | Queue holds FIFO_DEPTH entries |
| wr_ovf | output | 1 | Sticky flag: a push was dropped |
| pal_we | input | 1 | Palette entry write strobe |
| pal_idx | input | 8 | Palette entry index |
| pal_rgb | input | 9 | Colour to store, {r[2:0], g[2:0], b[2:0]} |
| sram_addr | output | 18 | SRAM address for the current slot |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable (write slot) |
| sram_oe | output | 1 | SRAM read enable (read slot, active pixel) |
| sram_rdata | input | 8 | SRAM read data, valid during the read slot |
| pix_rgb | output | 9 | Pixel colour |
| pix_de | output | 1 | Pixel colour belongs to an active position |
| pix_stb | output | 1 | New pixel presented this cycle |

## Verification
Each kind of internal fault shows up at the ports within a bounded number of cycles:

- **Slot phase out of step:** `sram_oe` or `sram_we` lands in the wrong cycle on the next read or write.
- **Raster or address counter drift:** the read address repeats or skips at the next active read slot, and the displayed colour stream loses order within a frame.
- **Corrupted queue pointer or count:** a wrong address or byte appears at the next write slot, a stored entry is dropped or repeated, or `wr_full` is raised at the wrong occupancy.
- **Read pipeline misalignment:** a colour that does not match the byte read three cycles earlier shows up at the next `pix_stb`.

// File: rtl/fbs_pkg.sv
// Shared widths and the queued write entry for the framebuffer slot scheduler.
// Assumes a byte-wide SRAM with an 18-bit word address and 3-3-3 colour.
package fbs_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int RGB_W  = 9;
    localparam int PAL_N  = 1 << DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;
endpackage

// File: rtl/fbs_wr_fifo.sv
// Host write queue: stores address+data entries, drops pushes when full and
// records the drop in a sticky flag. The head entry is visible combinationally.
// Assumes pop is only raised while the queue is not empty.
module fbs_wr_fifo
    import fbs_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output wr_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wr_entry_t        store [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic [CW-1:0]    cnt;
    logic             push_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign head    = store[rptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wptr] <= push_entry;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            case ({push_ok, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Sticky record of a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (push && full) begin
            ovf <= 1'b1;
        end
    end

    // R3: a push while full leaves the occupancy untouched.
    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R3: occupancy never exceeds the depth.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R4: the overflow flag never clears before reset.
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R2: a pop without a push removes exactly one entry.
    a_r2_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_ok) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fbs_scan_fetch.sv
// Slot phase and raster scan: toggles read/write phase every cycle, steps the
// raster position once per pixel period and keeps the linear read address
// y*H_ACTIVE+x without a multiplier. Assumes the frame fits in ADDR_W bits.
module fbs_scan_fetch
    import fbs_pkg::*;
#(
    parameter int H_ACTIVE = 800,
    parameter int H_TOTAL  = 1056,
    parameter int V_ACTIVE = 320,
    parameter int V_TOTAL  = 628
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              phase,
    output logic              rd_act,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int XW        = $clog2(H_TOTAL);
    localparam int YW        = $clog2(V_TOTAL);
    localparam int FRAME_PIX = H_ACTIVE * V_ACTIVE;

    logic [XW-1:0] fx;
    logic [YW-1:0] fy;
    logic          last_act;

    assign rd_act   = (fx < XW'(H_ACTIVE)) && (fy < YW'(V_ACTIVE));
    assign last_act = (fx == XW'(H_ACTIVE - 1)) && (fy == YW'(V_ACTIVE - 1));

    // Slot phase: 0 = read slot, 1 = write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    // Raster position advances at the end of each pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx <= '0;
            fy <= '0;
        end else if (phase) begin
            if (fx == XW'(H_TOTAL - 1)) begin
                fx <= '0;
                fy <= (fy == YW'(V_TOTAL - 1)) ? '0 : fy + 1'b1;
            end else begin
                fx <= fx + 1'b1;
            end
        end
    end

    // Linear read address steps only over active pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
        end else if (phase && rd_act) begin
            rd_addr <= last_act ? '0 : rd_addr + 1'b1;
        end
    end

    // R1: phase alternates every cycle.
    a_r1_phase_alt: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> !phase);

    // R5: an active read never addresses outside the frame.
    a_r5_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |-> (rd_addr < ADDR_W'(FRAME_PIX)));
endmodule

// File: rtl/fbs_palette_out.sv
// Read pipeline: captures the SRAM byte at the end of the read slot, looks it
// up in the palette during the write slot and registers the colour at the end
// of the next read slot. Blanking forces black. Palette RAM is not reset.
module fbs_palette_out
    import fbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              rd_act,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              pal_we,
    input  logic [DATA_W-1:0] pal_idx,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              pix_de,
    output logic              pix_stb
);
    logic [RGB_W-1:0]  pal_ram [PAL_N];
    logic [DATA_W-1:0] byte_q;
    logic              act1;
    logic [RGB_W-1:0]  pal_q;
    logic              act2;

    // Host update of palette entries.
    always_ff @(posedge clk) begin
        if (pal_we) begin
            pal_ram[pal_idx] <= pal_rgb;
        end
    end

    // Stage 1: capture the fetched byte at the end of the read slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            act1   <= 1'b0;
        end else if (!phase) begin
            byte_q <= rd_data;
            act1   <= rd_act;
        end
    end

    // Stage 2: palette lookup at the end of the write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q <= '0;
            act2  <= 1'b0;
        end else if (phase) begin
            pal_q <= pal_ram[byte_q];
            act2  <= act1;
        end
    end

    // Stage 3: present the colour, black outside the active area.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb <= '0;
            pix_de  <= 1'b0;
        end else if (!phase) begin
            pix_rgb <= act2 ? pal_q : '0;
            pix_de  <= act2;
        end
    end

    // Strobe marks the first cycle of each presented pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_stb <= 1'b0;
        end else begin
            pix_stb <= !phase;
        end
    end

    // R7: no colour leaves the block outside the active area.
    a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_de |-> (pix_rgb == '0));

    // R8: the strobe always falls in a write slot.
    a_r8_stb_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> phase);

    // R8: colour is held through the read slot that follows the strobe.
    a_r8_colour_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> $stable(pix_rgb));
endmodule

// File: rtl/fb_slot_sched.sv
// Top: time-slices one byte-wide SRAM between display reads (phase 0) and
// queued host writes (phase 1), and turns fetched bytes into palette colours.
// Assumes the SRAM returns read data within the read slot and takes a write
// at the clock edge that ends the write slot.
module fb_slot_sched
    import fbs_pkg::*;
#(
    parameter int H_ACTIVE   = 800,
    parameter int H_TOTAL    = 1056,
    parameter int V_ACTIVE   = 320,
    parameter int V_TOTAL    = 628,
    parameter int FIFO_DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_push,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_ovf,
    input  logic              pal_we,
    input  logic [DATA_W-1:0] pal_idx,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_we,
    output logic              sram_oe,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              pix_de,
    output logic              pix_stb
);
    logic              phase;
    logic              rd_act;
    logic [ADDR_W-1:0] rd_addr;
    wr_entry_t         head;
    logic              q_empty;
    logic              do_wr;

    fbs_scan_fetch #(
        .H_ACTIVE (H_ACTIVE),
        .H_TOTAL  (H_TOTAL),
        .V_ACTIVE (V_ACTIVE),
        .V_TOTAL  (V_TOTAL)
    ) scan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .rd_act  (rd_act),
        .rd_addr (rd_addr)
    );

    fbs_wr_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_push),
        .push_entry ('{addr: wr_addr, data: wr_data}),
        .pop        (do_wr),
        .head       (head),
        .empty      (q_empty),
        .full       (wr_full),
        .ovf        (wr_ovf)
    );

    fbs_palette_out pal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .rd_act  (rd_act),
        .rd_data (sram_rdata),
        .pal_we  (pal_we),
        .pal_idx (pal_idx),
        .pal_rgb (pal_rgb),
        .pix_rgb (pix_rgb),
        .pix_de  (pix_de),
        .pix_stb (pix_stb)
    );

    // Slot multiplexing of the SRAM bus.
    always_comb begin
        do_wr      = phase && !q_empty;
        sram_we    = do_wr;
        sram_oe    = !phase && rd_act;
        sram_addr  = phase ? head.addr : rd_addr;
        sram_wdata = head.data;
    end

    // R1: read and write enables never overlap.
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_oe && sram_we));

    // R1: a write slot is never followed by another write slot.
    a_r1_we_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |=> !sram_we);

    // R2: a full queue always produces a write in the write slot.
    a_r2_full_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && phase) |-> sram_we);
endmodule

// File: tb/fb_slot_sched_tb_top.sv
// Directed bench for the framebuffer slot scheduler with a small raster.
module fb_slot_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HA = 4;
    localparam int HT = 6;
    localparam int VA = 3;
    localparam int VT = 4;
    localparam int DEPTH = 8;
    localparam int FRAME_ACT = HA * VA;
    localparam int FRAME_CYC = 2 * HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_push = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_full;
    logic        wr_ovf;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_idx = '0;
    logic [8:0]  pal_rgb = '0;
    logic [17:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic        sram_we;
    logic        sram_oe;
    logic [7:0]  sram_rdata;
    logic [8:0]  pix_rgb;
    logic        pix_de;
    logic        pix_stb;

    int n_total = 0, n_bad = 0, m_total = 0, m_bad = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [7:0]  smem [0:4095];
    logic [8:0]  pal_ref [0:255];
    logic [17:0] q_addr [0:255];
    logic [7:0]  q_data [0:255];
    int q_wr = 0;
    int q_rd = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fb_slot_sched #(
        .H_ACTIVE (HA), .H_TOTAL (HT), .V_ACTIVE (VA), .V_TOTAL (VT),
        .FIFO_DEPTH (DEPTH)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .wr_push (wr_push), .wr_addr (wr_addr), .wr_data (wr_data),
        .wr_full (wr_full), .wr_ovf (wr_ovf),
        .pal_we (pal_we), .pal_idx (pal_idx), .pal_rgb (pal_rgb),
        .sram_addr (sram_addr), .sram_wdata (sram_wdata),
        .sram_we (sram_we), .sram_oe (sram_oe), .sram_rdata (sram_rdata),
        .pix_rgb (pix_rgb), .pix_de (pix_de), .pix_stb (pix_stb)
    );

    // SRAM model: asynchronous read, write at the edge; preloaded in reset.
    assign sram_rdata = smem[sram_addr[11:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++)
                smem[i] <= (i < FRAME_ACT) ? 8'((i * 13 + 7) & 255) : 8'h00;
        end else if (sram_we) begin
            smem[sram_addr[11:0]] <= sram_wdata;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic mcheck(input bit ok, input string what, input int act, input int exp);
        m_total++;
        if (!ok) begin
            m_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Continuous monitor: slots, read order, write order, pixel latency.
    bit         ph_ref = 1'b0;
    int         exp_raddr = 0;
    bit         h_oe [0:2];
    logic [8:0] h_exp [0:2];
    always @(negedge clk) begin
        if (!rst_n) begin
            ph_ref = 1'b0;
            exp_raddr = 0;
            for (int i = 0; i < 3; i++) h_oe[i] = 1'b0;
        end else begin
            mcheck(!(sram_oe && sram_we), "R1 oe and we together", 1, 0);
            if (sram_oe) mcheck(ph_ref == 1'b0, "R1 read outside read slot", ph_ref, 0);
            if (sram_we) mcheck(ph_ref == 1'b1, "R1 write outside write slot", ph_ref, 1);
            mcheck(pix_stb == ph_ref, "R8 strobe slot", pix_stb, ph_ref);
            if (ph_ref) mcheck(sram_we == (q_wr != q_rd), "R2 write enable vs queue", sram_we, q_wr != q_rd);
            if (sram_we) begin
                if (q_wr != q_rd) begin
                    mcheck(sram_addr == q_addr[q_rd % 256], "R2 write address order", sram_addr, q_addr[q_rd % 256]);
                    mcheck(sram_wdata == q_data[q_rd % 256], "R2 write data order", sram_wdata, q_data[q_rd % 256]);
                    q_rd = q_rd + 1;
                end
            end
            if (sram_oe) begin
                mcheck(sram_addr == 18'(exp_raddr), "R5 read address", sram_addr, exp_raddr);
                exp_raddr = (exp_raddr + 1) % FRAME_ACT;
            end
            if (pix_stb && !pix_de) mcheck(pix_rgb == 9'd0, "R7 blank colour", pix_rgb, 0);
            if (h_oe[2]) begin
                mcheck(pix_stb && pix_de, "R8 pixel three cycles after read", pix_stb && pix_de, 1);
                mcheck(pix_rgb == h_exp[2], "R6 palette colour", pix_rgb, h_exp[2]);
            end
            h_oe[2] = h_oe[1]; h_exp[2] = h_exp[1];
            h_oe[1] = h_oe[0]; h_exp[1] = h_exp[0];
            h_oe[0] = sram_oe && mon_on;
            h_exp[0] = pal_ref[sram_rdata];
            ph_ref = ~ph_ref;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sram_we == 1'b0, "R2 no write in reset", sram_we, 0);
        check(wr_full == 1'b0, "R3 not full after reset", wr_full, 0);
        check(wr_ovf == 1'b0, "R4 overflow clear after reset", wr_ovf, 0);
        check(pix_de == 1'b0, "R7 de low in reset", pix_de, 0);
        check(pix_rgb == 9'd0, "R7 black in reset", pix_rgb, 0);
        check(pix_stb == 1'b0, "R8 no strobe in reset", pix_stb, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic pal_write(input int idx, input logic [8:0] val);
        @(posedge clk); #1;
        pal_we = 1'b1; pal_idx = 8'(idx); pal_rgb = val;
        pal_ref[idx] = val;
        @(posedge clk); #1;
        pal_we = 1'b0;
    endtask

    task automatic t_pal_load();
        for (int i = 0; i < 256; i++) pal_write(i, 9'(((i * 37) | 1) & 511));
        repeat (4) @(posedge clk);
        #1 mon_on = 1'b1;
    endtask

    task automatic t_frame_read();
        int de_cnt = 0;
        int oe_cnt = 0;
        @(posedge clk); #1;
        for (int k = 0; k < 2 * FRAME_CYC; k++) begin
            @(negedge clk);
            if (pix_stb && pix_de) de_cnt++;
            if (sram_oe) oe_cnt++;
        end
        check(de_cnt == 2 * FRAME_ACT, "R5 active pixels per two frames", de_cnt, 2 * FRAME_ACT);
        check(oe_cnt == 2 * FRAME_ACT, "R5 reads per two frames", oe_cnt, 2 * FRAME_ACT);
    endtask

    task automatic t_pal_update();
        int hits = 0;
        logic [8:0] nv = 9'h0AA;
        #1 mon_on = 1'b0;
        pal_write((5 * 13 + 7) & 255, nv);
        repeat (4) @(posedge clk);
        #1 mon_on = 1'b1;
        for (int k = 0; k < FRAME_CYC; k++) begin
            @(negedge clk);
            if (pix_stb && pix_de && pix_rgb == nv) hits++;
        end
        check(hits == 1, "R6 updated entry shown once per frame", hits, 1);
    endtask

    task automatic t_fifo_order();
        logic [17:0] a [0:2] = '{18'd100, 18'd101, 18'd100};
        logic [7:0]  d [0:2] = '{8'h11, 8'h22, 8'h33};
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            wr_push = 1'b1; wr_addr = a[k]; wr_data = d[k];
            @(posedge clk); #1;
            wr_push = 1'b0;
            q_addr[q_wr % 256] = a[k]; q_data[q_wr % 256] = d[k];
            q_wr = q_wr + 1;
        end
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(smem[100] == 8'h33, "R2 later write wins", smem[100], 8'h33);
        check(smem[101] == 8'h22, "R2 second entry stored", smem[101], 8'h22);
        check(q_rd == q_wr, "R2 all entries retired", q_rd, q_wr);
        check(wr_ovf == 1'b0, "R4 no overflow without drop", wr_ovf, 0);
    endtask

    task automatic t_fifo_full();
        bit acc = 1'b0;
        bit saw_full = 1'b0;
        int rej = 0;
        int last_rej = 0;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #1;
            if (k > 0 && acc) begin
                q_addr[q_wr % 256] = wr_addr; q_data[q_wr % 256] = wr_data;
                q_wr = q_wr + 1;
            end
            wr_push = 1'b1; wr_addr = 18'(200 + k); wr_data = 8'(k + 1);
            acc = !wr_full;
            if (wr_full) begin
                saw_full = 1'b1;
                rej++;
                last_rej = 200 + k;
            end
        end
        @(posedge clk); #1;
        if (acc) begin
            q_addr[q_wr % 256] = wr_addr; q_data[q_wr % 256] = wr_data;
            q_wr = q_wr + 1;
        end
        wr_push = 1'b0;
        check(saw_full, "R3 full reached", saw_full, 1);
        check(rej > 0, "R3 pushes dropped while full", rej, 1);
        check(wr_ovf == 1'b1, "R4 overflow set by drop", wr_ovf, 1);
        repeat (3 * DEPTH + 4) @(posedge clk);
        @(negedge clk);
        check(q_rd == q_wr, "R3 accepted entries all written", q_rd, q_wr);
        check(wr_full == 1'b0, "R3 full clears after drain", wr_full, 0);
        check(smem[last_rej] == 8'h00, "R3 dropped entry not written", smem[last_rej], 0);
        check(wr_ovf == 1'b1, "R4 overflow stays set", wr_ovf, 1);
    endtask

    initial begin
        t_reset();
        t_pal_load();
        t_frame_read();
        t_pal_update();
        t_fifo_order();
        t_fifo_full();
        repeat (8) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total + m_total, n_bad + m_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_total + m_total + 1, n_bad + m_bad + 1);
            $finish;
        end
    end
endmodule